// File: doc/BRIEF.md
# Signed Fixed-Point Divider with Overflow Suppression

This block performs signed integer division for a general-register processor. It has two forms. The word form divides a dividend held in a register pair, or in one register extended by sign, by a full 32-bit divisor. The halfword form divides one 32-bit register by a 16-bit divisor extended by sign. Every operand is captured when `start` is accepted. The division itself runs on magnitudes in an iterative shift-subtract core, one quotient bit per clock. The signs are fixed up at the end. The result appears together with a single-cycle `done`.

With an even register number, the word form returns both results. The remainder goes to the addressed register and the quotient goes to its partner. With an odd register number, or in the halfword form, only the quotient is returned, to the addressed register. A quotient that does not fit in 32 signed bits counts as overflow. A zero divisor also counts as overflow. On overflow no register write is issued. Only the overflow bit of the condition code changes, and a trap request is raised if the arithmetic trap enable was set.

Top module: `fxdiv_unit`

## Requirements
- R1: For a word divide with `reg_odd`=0, the dividend is the signed 64-bit value {`r_val`,`r1_val`} (`r_val` high). Without overflow, the done cycle asserts both `wr_r_en` and `wr_r1_en`. The remainder is on `wr_r_data`, and the quotient, truncated toward zero, is on `wr_r1_data`.
- R2: A nonzero remainder carries the sign of the dividend, and the divisor's sign does not matter; its magnitude is below the divisor's magnitude.
- R3: For a word divide with `reg_odd`=1, the dividend is `r_val` extended by sign to 64 bits and `r1_val` is ignored. The quotient goes out on `wr_r_data` with `wr_r_en`=1, `wr_r1_en` stays 0, and the remainder is dropped.
- R4: For a halfword divide (`op_word`=0), the dividend is `r_val` and the divisor is `dvsr_in[15:0]` extended by sign; `dvsr_in[31:16]` is ignored. Only the quotient is written, on `wr_r_data`, whatever `reg_odd` is.
- R5: A quotient outside -2^31..2^31-1 is an overflow. In the done cycle both write enables stay 0, `cc_out[2]`=1, and `cc_out[3]`,`cc_out[1]`,`cc_out[0]` equal the captured `cc_in[2]`,`cc_in[1]`,`cc_in[0]`.
- R6: A divisor of zero, in either form, is handled as an overflow exactly as in R5.
- R7: Without overflow, the done cycle gives `cc_out[2]`=0 and `cc_out[3]` equal to the captured `cc_in[2]`. `cc_out[1:0]` gives the quotient's sign class: 2'b00 zero, 2'b01 negative, 2'b10 positive.
- R8: `trap_req` is high only in a done cycle with overflow, and only when `trap_en` was 1 at the time `start` was accepted.
- R9: `start` is accepted only while `busy`=0, and all inputs are sampled on that edge. `busy` is high from the next cycle until `done` falls. `done` is a one-cycle pulse that rises 64 clock edges after the edge that accepted `start`. A `start` while busy is ignored.
- R10: Outside the done cycle, `wr_r_en`, `wr_r1_en` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide |
| op_word | input | 1 | 1 = word form, 0 = halfword form |
| reg_odd | input | 1 | Parity of the register number |
| r_val | input | 32 | Contents of the addressed register |
| r1_val | input | 32 | Contents of the partner register |
| dvsr_in | input | 32 | Divisor (low 16 bits in halfword form) |
| cc_in | input | 3 | Current flags {CC1, CC3, CC4} |
| trap_en | input | 1 | Arithmetic trap enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result cycle pulse |
| wr_r_en | output | 1 | Write addressed register |
| wr_r_data | output | 32 | Data for addressed register |
| wr_r1_en | output | 1 | Write partner register |
| wr_r1_data | output | 32 | Data for partner register |
| cc_out | output | 4 | New flags {CC1, CC2, CC3, CC4}, valid with done |
| trap_req | output | 1 | Overflow trap request |

## Verification
The bench goes after the overflow edges: the quotient -2^31, which fits, and +2^31, which does not. A design with an off-by-one limit would write the first as an overflow or let the second through as a wrapped negative value. Mixed-sign operands test the remainder sign. A design that gave the remainder the divisor's sign, or that floored instead of truncating, would return 5 instead of -2 for -100/7. The odd-register and halfword runs put junk in the partner register and in the upper divisor bits, so a wrong operand selection shows as a wrong quotient or as a spurious partner write. A start pulsed mid-operation must produce no second result.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

  typedef enum logic [1:0] {
    FD_IDLE = 2'd0,
    FD_RUN  = 2'd1,
    FD_FIN  = 2'd2
  } fd_state_e;

  // Bit positions inside the 4-bit flag output
  localparam int CC1_POS = 3;
  localparam int OVF_POS = 2;

  // Sign class of a quotient: 00 zero, 01 negative, 10 positive
  function automatic logic [1:0] sign_class(input logic is_zero, input logic is_neg);
    if (is_zero)     return 2'b00;
    else if (is_neg) return 2'b01;
    else             return 2'b10;
  endfunction

endpackage

// File: rtl/fxdiv_operand.sv
module fxdiv_operand #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic           op_word,
  input  logic           reg_odd,
  input  logic [W-1:0]   r_val,
  input  logic [W-1:0]   r1_val,
  input  logic [W-1:0]   dvsr_in,
  output logic [2*W-1:0] dend_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           dend_neg,
  output logic           quo_neg,
  output logic           dvs_zero
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dend;
  logic [W-1:0]  dvs;
  logic          dvs_neg;

  always_comb begin
    if (op_word && !reg_odd) dend = {r_val, r1_val};
    else                     dend = {{W{r_val[W-1]}}, r_val};

    if (op_word) dvs = dvsr_in;
    else         dvs = {{(W-HW){dvsr_in[HW-1]}}, dvsr_in[HW-1:0]};

    dend_neg = dend[DW-1];
    dvs_neg  = dvs[W-1];
    dend_mag = dend_neg ? (~dend + DW'(1)) : dend;
    dvs_mag  = dvs_neg  ? (~dvs + W'(1))   : dvs;
    quo_neg  = dend_neg ^ dvs_neg;
    dvs_zero = (dvs == '0);
  end

endmodule

// File: rtl/fxdiv_core.sv
module fxdiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] dend_mag,
  input  logic [W-1:0]   dvs_mag,
  output logic [2*W-1:0] quo_mag,
  output logic [W-1:0]   rem_mag,
  output logic           last
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic [W-1:0]  rem_q, rem_n;
  logic [DW-1:0] quo_q, quo_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    cnt_n   = cnt_q;
    shifted = {rem_q, quo_q[DW-1]};
    trial   = shifted - {1'b0, dvs_q};
    if (load) begin
      rem_n = '0;
      quo_n = dend_mag;
      dvs_n = dvs_mag;
      cnt_n = CW'(DW);
    end else if (cnt_q != '0) begin
      if (!trial[W]) begin
        rem_n = trial[W-1:0];
        quo_n = {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_n = shifted[W-1:0];
        quo_n = {quo_q[DW-2:0], 1'b0};
      end
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
      cnt_q <= cnt_n;
    end
  end

  assign quo_mag = quo_q;
  assign rem_mag = rem_q;
  assign last    = (cnt_q == CW'(1));

endmodule

// File: rtl/fxdiv_result.sv
module fxdiv_result
  import fxdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           fire,
  input  logic [2*W-1:0] quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           quo_neg,
  input  logic           dend_neg,
  input  logic           dvs_zero,
  input  logic           is_word,
  input  logic           is_odd,
  input  logic [2:0]     cc_hold,
  input  logic           trap_on,
  output logic           wr_r_en,
  output logic [W-1:0]   wr_r_data,
  output logic           wr_r1_en,
  output logic [W-1:0]   wr_r1_data,
  output logic [3:0]     cc_out,
  output logic           trap_req
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] LIM_NEG = DW'(1) << (W - 1);
  localparam logic [DW-1:0] LIM_POS = LIM_NEG - DW'(1);

  logic         ovf;
  logic         pair;
  logic [W-1:0] q_val;
  logic [W-1:0] r_res;

  always_comb begin
    ovf   = dvs_zero || (quo_neg ? (quo_mag > LIM_NEG) : (quo_mag > LIM_POS));
    pair  = is_word && !is_odd;
    q_val = quo_neg ? (~quo_mag[W-1:0] + W'(1)) : quo_mag[W-1:0];
    r_res = dend_neg ? (~rem_mag + W'(1)) : rem_mag;

    wr_r_en    = 1'b0;
    wr_r1_en   = 1'b0;
    wr_r_data  = '0;
    wr_r1_data = '0;
    cc_out     = '0;
    trap_req   = 1'b0;
    if (fire) begin
      if (ovf) begin
        cc_out   = {cc_hold[2], 1'b1, cc_hold[1:0]};
        trap_req = trap_on;
      end else begin
        cc_out  = {cc_hold[2], 1'b0, sign_class(q_val == '0, q_val[W-1])};
        wr_r_en = 1'b1;
        if (pair) begin
          wr_r_data  = r_res;
          wr_r1_en   = 1'b1;
          wr_r1_data = q_val;
        end else begin
          wr_r_data = q_val;
        end
      end
    end
  end

endmodule

// File: rtl/fxdiv_unit.sv
module fxdiv_unit
  import fxdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_word,
  input  logic         reg_odd,
  input  logic [W-1:0] r_val,
  input  logic [W-1:0] r1_val,
  input  logic [W-1:0] dvsr_in,
  input  logic [2:0]   cc_in,
  input  logic         trap_en,
  output logic         busy,
  output logic         done,
  output logic         wr_r_en,
  output logic [W-1:0] wr_r_data,
  output logic         wr_r1_en,
  output logic [W-1:0] wr_r1_data,
  output logic [3:0]   cc_out,
  output logic         trap_req
);
  localparam int DW = 2 * W;

  fd_state_e state_q, state_n;
  logic      accept;
  logic      core_last;

  logic [DW-1:0] op_dend_mag;
  logic [W-1:0]  op_dvs_mag;
  logic          op_dend_neg, op_quo_neg, op_dvs_zero;

  logic [DW-1:0] quo_mag;
  logic [W-1:0]  rem_mag;

  // captured context
  logic       dend_neg_q, quo_neg_q, dvs_zero_q, word_q, odd_q, trap_q;
  logic [2:0] cc_q;

  assign accept = start && (state_q == FD_IDLE);

  fxdiv_operand #(.W(W), .HW(HW)) u_operand (
    .op_word  (op_word),
    .reg_odd  (reg_odd),
    .r_val    (r_val),
    .r1_val   (r1_val),
    .dvsr_in  (dvsr_in),
    .dend_mag (op_dend_mag),
    .dvs_mag  (op_dvs_mag),
    .dend_neg (op_dend_neg),
    .quo_neg  (op_quo_neg),
    .dvs_zero (op_dvs_zero)
  );

  fxdiv_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .dend_mag (op_dend_mag),
    .dvs_mag  (op_dvs_mag),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .last     (core_last)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      FD_IDLE: if (accept)    state_n = FD_RUN;
      FD_RUN:  if (core_last) state_n = FD_FIN;
      FD_FIN:                 state_n = FD_IDLE;
      default:                state_n = FD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FD_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dend_neg_q <= 1'b0;
      quo_neg_q  <= 1'b0;
      dvs_zero_q <= 1'b0;
      word_q     <= 1'b0;
      odd_q      <= 1'b0;
      trap_q     <= 1'b0;
      cc_q       <= '0;
    end else if (accept) begin
      dend_neg_q <= op_dend_neg;
      quo_neg_q  <= op_quo_neg;
      dvs_zero_q <= op_dvs_zero;
      word_q     <= op_word;
      odd_q      <= reg_odd;
      trap_q     <= trap_en;
      cc_q       <= cc_in;
    end
  end

  assign busy = (state_q != FD_IDLE);
  assign done = (state_q == FD_FIN);

  fxdiv_result #(.W(W)) u_result (
    .fire       (done),
    .quo_mag    (quo_mag),
    .rem_mag    (rem_mag),
    .quo_neg    (quo_neg_q),
    .dend_neg   (dend_neg_q),
    .dvs_zero   (dvs_zero_q),
    .is_word    (word_q),
    .is_odd     (odd_q),
    .cc_hold    (cc_q),
    .trap_on    (trap_q),
    .wr_r_en    (wr_r_en),
    .wr_r_data  (wr_r_data),
    .wr_r1_en   (wr_r1_en),
    .wr_r1_data (wr_r1_data),
    .cc_out     (cc_out),
    .trap_req   (trap_req)
  );

endmodule

// File: rtl/fxdiv_unit_chk.sv
module fxdiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         wr_r_en,
  input logic [W-1:0] wr_r_data,
  input logic         wr_r1_en,
  input logic [W-1:0] wr_r1_data,
  input logic [3:0]   cc_out,
  input logic         trap_req
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_write_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_r_en || wr_r1_en || trap_req) |-> done);

  p_overflow_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc_out[2]) |-> (!wr_r_en && !wr_r1_en));

  p_trap_needs_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> cc_out[2]);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cc_out[2]) |-> (wr_r_en && (cc_out[1:0] != 2'b11)));

  p_pair_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_r1_en |-> wr_r_en);

  p_zero_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cc_out[2]) |->
      ((wr_r1_en ? (wr_r1_data == '0) : (wr_r_data == '0)) == (cc_out[1:0] == 2'b00)));

endmodule

bind fxdiv_unit fxdiv_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .wr_r_en    (wr_r_en),
  .wr_r_data  (wr_r_data),
  .wr_r1_en   (wr_r1_en),
  .wr_r1_data (wr_r1_data),
  .cc_out     (cc_out),
  .trap_req   (trap_req)
);

// File: tb/fxdiv_unit_bench.sv
module fxdiv_unit_bench;

  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        op_word;
  logic        reg_odd;
  logic [31:0] r_val, r1_val, dvsr_in;
  logic [2:0]  cc_in;
  logic        trap_en;
  logic        busy, done, wr_r_en, wr_r1_en, trap_req;
  logic [31:0] wr_r_data, wr_r1_data;
  logic [3:0]  cc_out;

  always #4 clk = ~clk;  // 125 MHz

  fxdiv_unit u_fxdiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word), .reg_odd(reg_odd),
    .r_val(r_val), .r1_val(r1_val), .dvsr_in(dvsr_in), .cc_in(cc_in), .trap_en(trap_en),
    .busy(busy), .done(done), .wr_r_en(wr_r_en), .wr_r_data(wr_r_data),
    .wr_r1_en(wr_r1_en), .wr_r1_data(wr_r1_data), .cc_out(cc_out), .trap_req(trap_req)
  );

  typedef struct {
    string       tag;
    logic        hi_en;
    logic [31:0] hi_d;
    logic        lo_en;
    logic [31:0] lo_d;
    logic [3:0]  cc;
    logic        trap;
    logic        ovf;
    longint      due;
  } exp_t;

  exp_t   sb[$];
  int     n_chk = 0;
  int     n_err = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Driver: compute the expectation from the requirements and launch
  task automatic issue(input string tag, input bit word, input bit odd,
                       input logic [31:0] rv, input logic [31:0] r1v,
                       input logic [31:0] dv, input logic [2:0] cch, input bit tm);
    exp_t   e;
    longint dd, ds, q, r;
    bit     ovf;
    while (busy) @(negedge clk);
    dd = (word && !odd) ? longint'({rv, r1v}) : longint'($signed(rv));
    ds = word ? longint'($signed(dv)) : longint'($signed(dv[15:0]));
    ovf = (ds == 0) || (dd == 64'sh8000_0000_0000_0000 && ds == -1);
    q = 0; r = 0;
    if (!ovf) begin
      q = dd / ds;
      r = dd % ds;
      ovf = (q > 64'sd2147483647) || (q < -64'sd2147483648);
    end
    e.tag = tag; e.ovf = ovf;
    e.hi_en = 0; e.hi_d = '0; e.lo_en = 0; e.lo_d = '0;
    if (ovf) begin
      e.cc   = {cch[2], 1'b1, cch[1:0]};
      e.trap = tm;
    end else begin
      e.cc   = {cch[2], 1'b0, (q == 0) ? 2'b00 : (q < 0) ? 2'b01 : 2'b10};
      e.trap = 1'b0;
      e.hi_en = 1;
      if (word && !odd) begin
        e.hi_d = r[31:0]; e.lo_en = 1; e.lo_d = q[31:0];
      end else begin
        e.hi_d = q[31:0];
      end
    end
    e.due = cyc + 1 + 2 * W;
    sb.push_back(e);
    start = 1; op_word = word; reg_odd = odd; r_val = rv; r1_val = r1v;
    dvsr_in = dv; cc_in = cch; trap_en = tm;
    @(negedge clk);
    start = 0; r_val = 32'hDEAD_BEEF; r1_val = 32'h5A5A_A5A5; dvsr_in = 32'h1357_9BDF;
    cc_in = ~cch; trap_en = ~tm;
  endtask

  // Monitor: compare each result against the head of the queue
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, "R9", {e.tag, " latency"}, cyc, e.due);
        chk(wr_r_en == e.hi_en && (!e.hi_en || wr_r_data == e.hi_d),
            e.ovf ? "R5" : e.tag, {e.tag, " R write"},
            {wr_r_en, wr_r_data}, {e.hi_en, e.hi_d});
        chk(wr_r1_en == e.lo_en && (!e.lo_en || wr_r1_data == e.lo_d),
            e.ovf ? "R5" : e.tag, {e.tag, " R+1 write"},
            {wr_r1_en, wr_r1_data}, {e.lo_en, e.lo_d});
        chk(cc_out == e.cc, e.ovf ? "R5" : "R7", {e.tag, " flags"}, cc_out, e.cc);
        chk(trap_req == e.trap, "R8", {e.tag, " trap"}, trap_req, e.trap);
      end
    end else if (rst_n && busy) begin
      chk(!wr_r_en && !wr_r1_en && !trap_req, "R10", "enables outside done",
          {wr_r_en, wr_r1_en, trap_req}, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; op_word = 0; reg_odd = 0; r_val = '0; r1_val = '0;
    dvsr_in = '0; cc_in = '0; trap_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !wr_r_en && !wr_r1_en && !trap_req, "R10", "reset state",
        {busy, done, wr_r_en, wr_r1_en, trap_req}, 0);

    issue("R1", 1, 0, 32'h0, 32'd100, 32'd7, 3'b000, 0);               // q 14 r 2
    issue("R2", 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 3'b100, 0); // -100/7
    issue("R2", 1, 0, 32'h0, 32'd100, 32'hFFFF_FFF9, 3'b000, 1);       // 100/-7
    issue("R1", 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFEB, 32'hFFFF_FFF9, 3'b011, 0); // exact
    issue("R7", 1, 0, 32'h0, 32'h0, 32'd12345, 3'b111, 0);             // zero quotient
    issue("R1", 1, 0, 32'h0000_0012, 32'h3456_789A, 32'h0001_0000, 3'b000, 0);
    issue("R5", 1, 0, 32'h0000_0001, 32'h0, 32'd2, 3'b101, 1);         // +2^31 overflow
    issue("R5", 1, 0, 32'hFFFF_FFFF, 32'h0, 32'd2, 3'b010, 1);         // -2^31 fits
    issue("R6", 1, 0, 32'h0, 32'd55, 32'h0, 3'b110, 1);                // zero divisor
    issue("R6", 0, 0, 32'd55, 32'h0, 32'hFFFF_0000, 3'b001, 0);        // half zero
    issue("R3", 1, 1, 32'hFFFF_FFCE, 32'h7777_7777, 32'd8, 3'b100, 0); // -50/8
    issue("R3", 1, 1, 32'h7FFF_FFFF, 32'h1234_5678, 32'h1, 3'b000, 0);
    issue("R4", 0, 0, 32'd1000, 32'hCAFE_F00D, 32'hABCD_FFF6, 3'b100, 0); // /-10
    issue("R4", 0, 1, 32'hFFFF_F000, 32'h0, 32'h1111_0010, 3'b000, 0);    // /16
    issue("R5", 0, 0, 32'h8000_0000, 32'h0, 32'h0000_FFFF, 3'b111, 0);    // 2^31
    issue("R5", 1, 0, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 3'b011, 1);    // huge

    // R9: a start while busy must be ignored
    issue("R9", 1, 0, 32'h0, 32'd81, 32'd9, 3'b000, 0);
    repeat (5) @(negedge clk);
    start = 1; r1_val = 32'd1000; dvsr_in = 32'd3;
    @(negedge clk);
    start = 0;
    issue("R1", 1, 0, 32'h0, 32'd1, 32'd1, 3'b000, 0);

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9", "idle after last", {busy, done}, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule